// File: doc/BRIEF.md
# Command-Response Buffer Control Block

This block is the device-side register front end of a command-response buffer interface. A host reaches it over a plain 32-bit register bus with a synchronous read. It first claims locality 0 and moves the device from idle to ready. It then fills a shared data window, sets the start bit and polls until the device clears that bit. The actual command execution lives outside, in an abstract processor. That processor receives a one-cycle go pulse and answers with a one-cycle done pulse.

Power-state requests clear themselves once their transition finishes. Each transition lasts a fixed number of cycles set by a parameter, so a polling host sees the request bit held for a known time. Cancellation pulls the start bit back to zero at once. The command and response windows are the same storage, so both report the same base and the same size.

Top module: `crbif_regs`

## Requirements
- R1: After reset, locality state (0x00) reads 0x80, control status (0x44) reads 0x2 (idle), start (0x4C) reads 0, interface ID (0x30) reads 0x1 and proc_go_o is 0.
- R2: Writing locality control (0x08) with bit 0 set grants locality 0 on that edge. Locality state then reads bit 1 (assigned) and bit 0 (established, sticky) as 1 with bit 7 (valid) still 1, giving 0x83. Locality status (0x0C) bit 0 reads 1.
- R3: Writing locality control with bit 1 set clears the assigned bit one cycle after the write edge, so a read right after shows 0x83 and the next shows 0x81. When bits 0 and 1 are written together, bit 1 wins.
- R4: Writing control request (0x40) bit 0 (go-ready) makes that bit read 1 for exactly READY_LAT consecutive reads. It then reads 0, the device is ready and the idle flag (0x44 bit 1) is 0.
- R5: Writing control request bit 1 (go-idle) makes that bit read 1 for exactly IDLE_LAT reads. After that the idle flag is 1. When both bits are written, go-idle wins and bit 0 stays 0. Any control request written while a command runs is ignored.
- R6: A write of 1 to start bit 0 is accepted only while locality 0 is assigned and the device is ready. It then reads 1 and proc_go_o is high for exactly one cycle. Otherwise start stays 0 and no pulse is made.
- R7: Start stays 1 until cmd_done_i is sampled high, and it reads 0 from the following read. A done pulse while no command runs changes nothing.
- R8: Writing cancel (0x48) with bit 0 set stores 1 (read back, and on proc_abort_o) and clears a running start on the same edge. Writing 0 clears the stored cancel.
- R9: A fault_i pulse sets the error flag (0x44 bit 0). It is cleared when a go-idle transition completes.
- R10: Interrupt enable (0x50) keeps only bit 31, reads other bits as 0, and drives irq_en_o.
- R11: Command size (0x58) and response size (0x64) both read BUF_WORDS*4. Both low address registers (0x5C, 0x68) read 0x80, and both high halves (0x60, 0x6C) read 0.
- R12: The data window from 0x80 stores 32-bit words with per-byte write enables (bus_be) and returns them on read.
- R13: Read data appears the cycle after the address is presented. Unmapped register addresses and interrupt status (0x54) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables, used by the data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| cmd_done_i | input | 1 | Completion pulse from the command processor |
| fault_i | input | 1 | Fault pulse that sets the error flag |
| proc_go_o | output | 1 | One-cycle pulse when a command is accepted |
| proc_abort_o | output | 1 | Stored cancel request |
| irq_en_o | output | 1 | Global interrupt enable |

## Verification
The assertions assume that cmd_done_i and fault_i are single-cycle pulses. They also assume the bus holds a write for exactly one cycle, with no read strobe, so a register read has no side effect. The stimulus drives every input at the falling edge, one access per cycle. It raises cmd_done_i only after a command has been started, apart from one deliberate stray pulse. It confines random addresses to the data window and the interrupt-enable register, so random traffic never disturbs the handshake state.

// File: rtl/crbif_pkg.sv
package crbif_pkg;
  // Register byte offsets decoded by the host driver
  localparam logic [31:0] OFF_LOC_STATE = 32'h00;
  localparam logic [31:0] OFF_LOC_CTRL  = 32'h08;
  localparam logic [31:0] OFF_LOC_STS   = 32'h0C;
  localparam logic [31:0] OFF_IF_ID     = 32'h30;
  localparam logic [31:0] OFF_CTRL_EXT  = 32'h38;
  localparam logic [31:0] OFF_CTRL_REQ  = 32'h40;
  localparam logic [31:0] OFF_CTRL_STS  = 32'h44;
  localparam logic [31:0] OFF_CANCEL    = 32'h48;
  localparam logic [31:0] OFF_START     = 32'h4C;
  localparam logic [31:0] OFF_INT_EN    = 32'h50;
  localparam logic [31:0] OFF_INT_STS   = 32'h54;
  localparam logic [31:0] OFF_CMD_SIZE  = 32'h58;
  localparam logic [31:0] OFF_CMD_LO    = 32'h5C;
  localparam logic [31:0] OFF_CMD_HI    = 32'h60;
  localparam logic [31:0] OFF_RSP_SIZE  = 32'h64;
  localparam logic [31:0] OFF_RSP_LO    = 32'h68;
  localparam logic [31:0] OFF_RSP_HI    = 32'h6C;
  localparam logic [31:0] BUF_BASE      = 32'h80;

  localparam logic [31:0] IF_KIND       = 32'h1;

  typedef enum logic [1:0] {
    PW_IDLE     = 2'd0,
    PW_TO_READY = 2'd1,
    PW_READY    = 2'd2,
    PW_TO_IDLE  = 2'd3
  } pwr_e;
endpackage

// File: rtl/crbif_locality.sv
module crbif_locality (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic rel_i,
  output logic assigned_o,
  output logic established_o
);
  logic rel_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_pend_q    <= 1'b0;
      assigned_o    <= 1'b0;
      established_o <= 1'b0;
    end else begin
      rel_pend_q <= rel_i;
      if (rel_i) begin
        // relinquish takes priority; assigned drops on the next edge
      end else if (req_i) begin
        assigned_o    <= 1'b1;
        established_o <= 1'b1;
      end else if (rel_pend_q) begin
        assigned_o <= 1'b0;
      end
    end
  end

  assert_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (req_i && !rel_i) |=> (assigned_o && established_o));

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (rel_i ##1 !req_i) |=> !assigned_o);
endmodule

// File: rtl/crbif_power.sv
module crbif_power
  import crbif_pkg::*;
#(
  parameter int READY_LAT = 4,
  parameter int IDLE_LAT  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic go_ready_i,
  input  logic go_idle_i,
  input  logic busy_i,
  input  logic fault_i,
  output logic ready_o,
  output logic idle_o,
  output logic ready_pend_o,
  output logic idle_pend_o,
  output logic err_o
);
  localparam int MAXLAT = (READY_LAT > IDLE_LAT) ? READY_LAT : IDLE_LAT;
  localparam int CW     = $clog2(MAXLAT + 1);

  pwr_e            st_q;
  logic [CW-1:0]   cnt_q;
  logic            take_idle, take_ready;

  assign take_idle  = go_idle_i && !busy_i;
  assign take_ready = go_ready_i && !go_idle_i && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= PW_IDLE;
      cnt_q        <= '0;
      ready_pend_o <= 1'b0;
      idle_pend_o  <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      if (take_idle) begin
        st_q         <= PW_TO_IDLE;
        cnt_q        <= CW'(IDLE_LAT - 1);
        idle_pend_o  <= 1'b1;
        ready_pend_o <= 1'b0;
      end else if (take_ready) begin
        st_q         <= PW_TO_READY;
        cnt_q        <= CW'(READY_LAT - 1);
        ready_pend_o <= 1'b1;
        idle_pend_o  <= 1'b0;
      end else if (st_q == PW_TO_READY) begin
        if (cnt_q == '0) begin
          st_q         <= PW_READY;
          ready_pend_o <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (st_q == PW_TO_IDLE) begin
        if (cnt_q == '0) begin
          st_q        <= PW_IDLE;
          idle_pend_o <= 1'b0;
          err_o       <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (fault_i) err_o <= 1'b1;
    end
  end

  assign ready_o = (st_q == PW_READY);
  assign idle_o  = (st_q == PW_IDLE);

  assert_ready_done_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == PW_TO_READY && cnt_q == '0 && !go_idle_i && !go_ready_i)
      |=> (ready_o && !ready_pend_o));

  assert_idle_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_o) |-> $past(idle_pend_o));

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !ready_pend_o && !idle_pend_o) |=> (!ready_pend_o && !idle_pend_o));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(idle_o) && !$past(fault_i)) |-> !err_o);
endmodule

// File: rtl/crbif_cmd.sv
module crbif_cmd (
  input  logic clk,
  input  logic rst,
  input  logic start_wr_i,
  input  logic cancel_wr_i,
  input  logic cancel_val_i,
  input  logic allow_i,
  input  logic done_i,
  output logic start_o,
  output logic go_o,
  output logic cancel_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_o  <= 1'b0;
      go_o     <= 1'b0;
      cancel_o <= 1'b0;
    end else begin
      go_o <= 1'b0;
      if (cancel_wr_i) cancel_o <= cancel_val_i;
      if (start_o && cancel_wr_i && cancel_val_i) begin
        start_o <= 1'b0;
      end else if (start_o && done_i) begin
        start_o <= 1'b0;
      end else if (!start_o && start_wr_i && allow_i) begin
        start_o <= 1'b1;
        go_o    <= 1'b1;
      end
    end
  end

  assert_go_single_R6: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o);

  assert_start_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(start_o) |-> $past(allow_i && start_wr_i));

  assert_done_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (start_o && done_i) |=> !start_o);

  assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
    (start_o && cancel_wr_i && cancel_val_i) |=> (!start_o && cancel_o));
endmodule

// File: rtl/crbif_buffer.sv
module crbif_buffer #(
  parameter int WORDS = 32,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (we && be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/crbif_regs.sv
module crbif_regs
  import crbif_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BUF_WORDS = 32,
  parameter int READY_LAT = 4,
  parameter int IDLE_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cmd_done_i,
  input  logic              fault_i,
  output logic              proc_go_o,
  output logic              proc_abort_o,
  output logic              irq_en_o
);
  localparam int          BW        = $clog2(BUF_WORDS);
  localparam logic [31:0] BUF_BYTES = 32'(BUF_WORDS * 4);

  logic [31:0] a32;
  logic        in_buf;
  logic [BW-1:0] buf_word;
  logic        assigned, established;
  logic        ready, idle, ready_pend, idle_pend, err;
  logic        start;
  logic        wr_loc, wr_req, wr_start, wr_cancel, wr_ien;
  logic [31:0] reg_rd, rd_q, mem_rd;
  logic        sel_q;

  function automatic logic at(input logic [31:0] a, input logic [31:0] off);
    return a[31:2] == off[31:2];
  endfunction

  assign a32      = 32'(bus_addr);
  assign in_buf   = (a32 >= BUF_BASE) && (a32 < BUF_BASE + BUF_BYTES);
  assign buf_word = BW'((a32 - BUF_BASE) >> 2);

  assign wr_loc    = bus_wr && at(a32, OFF_LOC_CTRL);
  assign wr_req    = bus_wr && at(a32, OFF_CTRL_REQ);
  assign wr_start  = bus_wr && at(a32, OFF_START) && bus_wdata[0];
  assign wr_cancel = bus_wr && at(a32, OFF_CANCEL);
  assign wr_ien    = bus_wr && at(a32, OFF_INT_EN);

  crbif_locality u_loc (
    .clk          (clk),
    .rst          (rst),
    .req_i        (wr_loc && bus_wdata[0]),
    .rel_i        (wr_loc && bus_wdata[1]),
    .assigned_o   (assigned),
    .established_o(established)
  );

  crbif_power #(.READY_LAT(READY_LAT), .IDLE_LAT(IDLE_LAT)) u_pwr (
    .clk         (clk),
    .rst         (rst),
    .go_ready_i  (wr_req && bus_wdata[0]),
    .go_idle_i   (wr_req && bus_wdata[1]),
    .busy_i      (start),
    .fault_i     (fault_i),
    .ready_o     (ready),
    .idle_o      (idle),
    .ready_pend_o(ready_pend),
    .idle_pend_o (idle_pend),
    .err_o       (err)
  );

  crbif_cmd u_cmd (
    .clk         (clk),
    .rst         (rst),
    .start_wr_i  (wr_start),
    .cancel_wr_i (wr_cancel),
    .cancel_val_i(bus_wdata[0]),
    .allow_i     (assigned && ready),
    .done_i      (cmd_done_i),
    .start_o     (start),
    .go_o        (proc_go_o),
    .cancel_o    (proc_abort_o)
  );

  crbif_buffer #(.WORDS(BUF_WORDS), .AW(BW)) u_buf (
    .clk  (clk),
    .we   (bus_wr && in_buf),
    .be   (bus_be),
    .addr (buf_word),
    .wdata(bus_wdata),
    .rdata(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_en_o <= 1'b0;
    else if (wr_ien) irq_en_o <= bus_wdata[31];
  end

  always_comb begin
    reg_rd = '0;
    if (at(a32, OFF_LOC_STATE))     reg_rd = {24'd0, 1'b1, 5'd0, assigned, established};
    else if (at(a32, OFF_LOC_STS))  reg_rd = {31'd0, assigned};
    else if (at(a32, OFF_IF_ID))    reg_rd = IF_KIND;
    else if (at(a32, OFF_CTRL_REQ)) reg_rd = {30'd0, idle_pend, ready_pend};
    else if (at(a32, OFF_CTRL_STS)) reg_rd = {30'd0, idle, err};
    else if (at(a32, OFF_CANCEL))   reg_rd = {31'd0, proc_abort_o};
    else if (at(a32, OFF_START))    reg_rd = {31'd0, start};
    else if (at(a32, OFF_INT_EN))   reg_rd = {irq_en_o, 31'd0};
    else if (at(a32, OFF_CMD_SIZE) || at(a32, OFF_RSP_SIZE)) reg_rd = BUF_BYTES;
    else if (at(a32, OFF_CMD_LO) || at(a32, OFF_RSP_LO))     reg_rd = BUF_BASE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      rd_q  <= reg_rd;
      sel_q <= in_buf;
    end
  end

  assign bus_rdata = sel_q ? mem_rd : rd_q;

  assert_irq_en_R10: assert property (@(posedge clk) disable iff (rst)
    wr_ien |=> (irq_en_o == $past(bus_wdata[31])));

  assert_read_lat_R13: assert property (@(posedge clk) disable iff (rst)
    (!in_buf && at(a32, OFF_START)) |=> (bus_rdata == {31'd0, $past(start)}));
endmodule

// File: tb/crbif_regs_tb.sv
module crbif_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RLAT  = 4;
  localparam int ILAT  = 3;
  localparam int WORDS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_done_i = 1'b0;
  logic        fault_i = 1'b0;
  logic        proc_go_o, proc_abort_o, irq_en_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  crbif_regs #(.ADDR_W(12), .BUF_WORDS(WORDS), .READY_LAT(RLAT), .IDLE_LAT(ILAT)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_done_i(cmd_done_i),
    .fault_i(fault_i), .proc_go_o(proc_go_o), .proc_abort_o(proc_abort_o),
    .irq_en_o(irq_en_o)
  );

  function automatic logic [31:0] loc_exp(input logic asg, input logic est);
    return 32'h80 | {30'd0, asg, est};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_addr = a[11:0]; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a[11:0];
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    cmd_done_i = 1'b1; @(negedge clk); cmd_done_i = 1'b0;
  endtask

  task automatic poll(input logic [31:0] bitmask, output int cnt);
    logic [31:0] d;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      rd(32'h40, d);
      if ((d & bitmask) == 0) break;
      cnt++;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d, v;
    int cnt;
    int unsigned seedv;
    seedv = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(32'h00, d); check("R1 loc state", d, 32'h80);
    rd(32'h44, d); check("R1 ctrl sts", d, 32'h2);
    rd(32'h4C, d); check("R1 start", d, 32'h0);
    rd(32'h30, d); check("R1 if id", d, 32'h1);
    check("R1 go", {31'd0, proc_go_o}, 32'h0);

    // R11 and R13 fixed registers
    rd(32'h58, d); check("R11 cmd size", d, WORDS * 4);
    rd(32'h64, d); check("R11 rsp size", d, WORDS * 4);
    rd(32'h5C, d); check("R11 cmd lo", d, 32'h80);
    rd(32'h68, d); check("R11 rsp lo", d, 32'h80);
    rd(32'h60, d); check("R11 cmd hi", d, 32'h0);
    rd(32'h6C, d); check("R11 rsp hi", d, 32'h0);
    rd(32'h54, d); check("R13 int sts", d, 32'h0);
    rd(32'h20, d); check("R13 unmapped", d, 32'h0);

    // R6 rejected without locality
    wr(32'h4C, 32'h1);
    check("R6 no go without locality", {31'd0, proc_go_o}, 32'h0);
    rd(32'h4C, d); check("R6 start rejected", d, 32'h0);

    // R2 grant
    wr(32'h08, 32'h1);
    rd(32'h00, d); check("R2 loc state", d, loc_exp(1'b1, 1'b1));
    rd(32'h0C, d); check("R2 loc sts", d, 32'h1);

    // R6 rejected while idle
    wr(32'h4C, 32'h1);
    rd(32'h4C, d); check("R6 start rejected idle", d, 32'h0);

    // R4 go-ready
    wr(32'h40, 32'h1);
    poll(32'h1, cnt); check("R4 ready latency", cnt, RLAT);
    rd(32'h44, d); check("R4 idle cleared", d, 32'h0);

    // R6 accepted
    wr(32'h4C, 32'h1);
    check("R6 go pulse", {31'd0, proc_go_o}, 32'h1);
    rd(32'h4C, d); check("R6 start set", d, 32'h1);
    check("R6 go single", {31'd0, proc_go_o}, 32'h0);

    // R5 request ignored while running
    wr(32'h40, 32'h2);
    rd(32'h40, d); check("R5 ignored busy", d, 32'h0);
    rd(32'h44, d); check("R5 not idle busy", d, 32'h0);

    // R7 completion
    rd(32'h4C, d); check("R7 still running", d, 32'h1);
    pulse_done();
    rd(32'h4C, d); check("R7 done clears", d, 32'h0);
    pulse_done();
    rd(32'h4C, d); check("R7 stray done", d, 32'h0);

    // R8 cancel
    wr(32'h4C, 32'h1);
    wr(32'h48, 32'h1);
    rd(32'h4C, d); check("R8 start cleared", d, 32'h0);
    rd(32'h48, d); check("R8 cancel readback", d, 32'h1);
    check("R8 abort out", {31'd0, proc_abort_o}, 32'h1);
    wr(32'h48, 32'h0);
    rd(32'h48, d); check("R8 cancel cleared", d, 32'h0);
    check("R8 abort low", {31'd0, proc_abort_o}, 32'h0);

    // R9 error then go-idle clears it
    fault_i = 1'b1; @(negedge clk); fault_i = 1'b0;
    rd(32'h44, d); check("R9 err set", d, 32'h1);
    wr(32'h40, 32'h2);
    poll(32'h2, cnt); check("R5 idle latency", cnt, ILAT);
    rd(32'h44, d); check("R9 err cleared, R5 idle", d, 32'h2);

    // R5 priority when both written
    wr(32'h40, 32'h3);
    rd(32'h40, d); check("R5 idle wins", d, 32'h2);
    poll(32'h2, cnt); check("R5 idle latency again", cnt, ILAT - 1);

    // R3 relinquish, and priority when both bits written
    wr(32'h08, 32'h2);
    rd(32'h00, d); check("R3 assigned held one cycle", d, loc_exp(1'b1, 1'b1));
    rd(32'h00, d); check("R3 released", d, loc_exp(1'b0, 1'b1));
    wr(32'h08, 32'h1);
    wr(32'h08, 32'h3);
    rd(32'h00, d); check("R3 both bits first", d, loc_exp(1'b1, 1'b1));
    rd(32'h00, d); check("R3 both bits release", d, loc_exp(1'b0, 1'b1));

    // R10 random interrupt enable writes
    for (int i = 0; i < 8; i++) begin
      v = $urandom;
      wr(32'h50, v);
      rd(32'h50, d); check("R10 int en readback", d, {v[31], 31'd0});
      check("R10 irq_en_o", {31'd0, irq_en_o}, {31'd0, v[31]});
    end

    // R12 data window: full fill, random partial writes, readback
    for (int i = 0; i < WORDS; i++) begin
      v = $urandom; model[i] = v;
      wr(32'h80 + 4 * i, v);
    end
    for (int i = 0; i < 40; i++) begin
      int w;
      logic [3:0] be;
      w = int'($urandom_range(WORDS - 1, 0));
      be = 4'($urandom);
      v = $urandom;
      model[w] = merge(model[w], v, be);
      wr(32'h80 + 4 * w, v, be);
    end
    for (int i = 0; i < WORDS; i++) begin
      rd(32'h80 + 4 * i, d); check("R12 buffer word", d, model[i]);
    end
    rd(32'h4C, d); check("R13 register after buffer", d, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule